// File: doc/BRIEF.md
# Sector Page-Load and Program Controller

This block is the write path of a byte-wide memory that is organized in sectors of 256 bytes. A host writes single bytes with a one-cycle strobe that carries an address and a data byte. The first strobe opens a load phase and latches the sector address. During that phase the bytes of that sector can be loaded in any order into an internal page buffer. When the host stops writing for a programmable number of cycles, the load phase closes. A timed program cycle then erases the sector and writes the whole buffer into the storage array at once. Any byte that was not loaded is stored as 0xFF.

While the block is busy, a read returns a status byte instead of array data. The status byte lets software wait for the end of the cycle in either of two ways: by watching bit 7, which holds the inverse of bit 7 of the byte loaded most recently, or by watching bit 6, which flips on each read. Once programming ends, reads return array contents again. The storage array is a behavioural RAM inside the block, initialised to the erased value 0xFF at reset. Both timing windows are parameters counted in clock cycles.

Top module: `sector_prog_ctrl`

## Requirements
- R1: An address splits into a byte index in bits [7:0] and a sector number in the bits above. Programming one sector changes no byte of any other sector.
- R2: Within a load phase, bytes may be loaded in any order. When the same index is loaded more than once, the last value loaded is the one programmed.
- R3: The load phase ends after LOAD_WINDOW consecutive cycles with no accepted load. A load accepted in the last cycle of the window restarts the window.
- R4: Every byte of the programmed sector that was not loaded in that phase reads 0xFF afterwards, whatever it held before.
- R5: The program cycle lasts PROG_CYCLES cycles. busy falls exactly LOAD_WINDOW + PROG_CYCLES clock edges after the edge that accepted the last load, and at that same edge the buffer is committed to the array.
- R6: A read while busy returns bit 7 equal to the inverse of bit 7 of the most recently loaded byte, with bits 5:0 equal to zero.
- R7: Bit 6 of status reads is 0 on the first busy read of a phase and inverts on every following busy read. Once busy is low, reads return true array data.
- R8: A load to a different sector during a load phase is ignored and does not restart the window. It sets sector_err, which stays set until reset.
- R9: Write strobes during the program cycle are ignored and change no array byte.
- R10: After reset, busy, sector_err and rd_valid are 0. busy rises on the edge that accepts the first load of a phase.
- R11: A read issued while idle returns the array byte one cycle later, with rd_valid high. An unwritten location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-load strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Load address: sector number above, byte index below |
| wr_data | input | 8 | Byte to load |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte, or the status byte while busy |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| busy | output | 1 | A load phase or a program cycle is in progress |
| sector_err | output | 1 | Sticky flag set by a load to a different sector |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a byte load and the expiry of the load window. The bench places a load on the last edge of the window and judges the outcome in two ways: both bytes of the phase must be present afterwards, and busy must fall a full window plus program time after the late load. The second pair is a status read and the commit of the sector. The bench issues a read on the exact commit edge and expects the status byte, with bit 6 continuing the toggle sequence. It then expects busy to be low and the next read to return the newly programmed data.

// File: rtl/spc_pkg.sv
package spc_pkg;
   localparam int unsigned DATA_BITS = 8;
   localparam logic [DATA_BITS-1:0] ERASED = 8'hFF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } spc_state_e;
endpackage

// File: rtl/spc_interval.sv
module spc_interval #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic expire
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("spc_interval: LIMIT must be at least 2");
   end

   logic [CW-1:0] count;

   assign expire = tick && !clear && (count == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear || expire) begin
         count <= '0;
      end else if (tick) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/spc_sector_buf.sv
module spc_sector_buf #(
   parameter int unsigned IDX_W = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   fill,
   input  logic                                   wr,
   input  logic [IDX_W-1:0]                       idx,
   input  logic [spc_pkg::DATA_BITS-1:0]          data,
   output logic [(1<<IDX_W)-1:0][spc_pkg::DATA_BITS-1:0] bytes_q
);
   localparam int unsigned NB = 1 << IDX_W;

   for (genvar g = 0; g < NB; g++) begin : g_byte
      logic hit;
      assign hit = (fill || wr) && (idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bytes_q[g] <= spc_pkg::ERASED;
         end else if (hit) begin
            bytes_q[g] <= data;
         end else if (fill) begin
            bytes_q[g] <= spc_pkg::ERASED;
         end
      end
   end
endmodule

// File: rtl/spc_array.sv
module spc_array #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned IDX_W  = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   commit,
   input  logic [ADDR_W-IDX_W-1:0]                commit_sect,
   input  logic [(1<<IDX_W)-1:0][spc_pkg::DATA_BITS-1:0] bytes_in,
   input  logic                                   rd_en,
   input  logic [ADDR_W-1:0]                      rd_addr,
   input  logic                                   status_mode,
   input  logic [spc_pkg::DATA_BITS-1:0]          status_byte,
   output logic [spc_pkg::DATA_BITS-1:0]          rd_data,
   output logic                                   rd_valid
);
   localparam int unsigned NBYTES = 1 << ADDR_W;
   localparam int unsigned NB     = 1 << IDX_W;

   logic [spc_pkg::DATA_BITS-1:0] mem [NBYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NBYTES; i++) begin
            mem[i] <= spc_pkg::ERASED;
         end
      end else if (commit) begin
         for (int i = 0; i < NB; i++) begin
            mem[{commit_sect, IDX_W'(i)}] <= bytes_in[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= status_mode ? status_byte : mem[rd_addr];
         end
      end
   end
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl #(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned IDX_W       = 8,
   parameter int unsigned LOAD_WINDOW = 30000,
   parameter int unsigned PROG_CYCLES = 2000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              sector_err
);
   import spc_pkg::*;

   localparam int unsigned SECT_W = ADDR_W - IDX_W;
   localparam int unsigned NB     = 1 << IDX_W;

   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("sector_prog_ctrl: ADDR_W must exceed IDX_W");
   end
   if (ADDR_W > 16) begin : g_bad_size
      $error("sector_prog_ctrl: behavioural array limited to 16 address bits");
   end
   if (IDX_W != 8) begin : g_bad_idx
      $error("sector_prog_ctrl: sectors hold 256 bytes, IDX_W must be 8");
   end

   spc_state_e          state;
   logic [SECT_W-1:0]   cur_sect;
   logic [7:0]          last_data;
   logic                tog;

   logic [IDX_W-1:0]    wr_idx;
   logic [SECT_W-1:0]   wr_sect;
   logic                first_load, more_load, bad_load;
   logic                load_exp, prog_exp;
   logic [NB-1:0][7:0]  buf_bytes;
   logic [7:0]          status_byte;

   assign wr_idx     = wr_addr[IDX_W-1:0];
   assign wr_sect    = wr_addr[ADDR_W-1:IDX_W];
   assign first_load = (state == ST_IDLE) && wr_en;
   assign more_load  = (state == ST_LOAD) && wr_en && (wr_sect == cur_sect);
   assign bad_load   = (state == ST_LOAD) && wr_en && (wr_sect != cur_sect);
   assign busy       = (state != ST_IDLE);
   assign status_byte = {~last_data[7], tog, 6'b000000};

   spc_interval #(.LIMIT(LOAD_WINDOW)) u_load_win (
      .clk   (clk),
      .rst_n (rst_n),
      .clear ((state != ST_LOAD) || more_load),
      .tick  ((state == ST_LOAD) && !more_load),
      .expire(load_exp)
   );

   spc_interval #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != ST_PROG),
      .tick  (state == ST_PROG),
      .expire(prog_exp)
   );

   spc_sector_buf #(.IDX_W(IDX_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill   (first_load),
      .wr     (more_load),
      .idx    (wr_idx),
      .data   (wr_data),
      .bytes_q(buf_bytes)
   );

   spc_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (prog_exp),
      .commit_sect(cur_sect),
      .bytes_in   (buf_bytes),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .status_mode(busy),
      .status_byte(status_byte),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_sect   <= '0;
         last_data  <= '0;
         tog        <= 1'b0;
         sector_err <= 1'b0;
      end else begin
         if (rd_en && busy) begin
            tog <= ~tog;
         end
         unique case (state)
            ST_IDLE: begin
               if (wr_en) begin
                  state     <= ST_LOAD;
                  cur_sect  <= wr_sect;
                  last_data <= wr_data;
                  tog       <= 1'b0;
               end
            end
            ST_LOAD: begin
               if (more_load) begin
                  last_data <= wr_data;
               end else if (load_exp) begin
                  state <= ST_PROG;
               end
               if (bad_load) begin
                  sector_err <= 1'b1;
               end
            end
            ST_PROG: begin
               if (prog_exp) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r10_busy_starts_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en));

   a_r5_busy_ends_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(state == ST_PROG));

   a_r3_load_holds_window: assert property (@(posedge clk) disable iff (!rst_n)
      more_load |=> (state == ST_LOAD));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sector_err |=> sector_err);

   a_r8_bad_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
      bad_load |=> (sector_err && $stable(cur_sect)));

   a_r9_prog_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PROG) && wr_en) |=> ($stable(last_data) && $stable(cur_sect)));

   a_r6_status_bit7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rd_valid && (rd_data[7] == ~$past(last_data[7])) && (rd_data[5:0] == 6'd0)));

   a_r7_toggle_bit6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) ##1 (rd_en && busy) |=> (rd_data[6] != $past(rd_data[6])));
endmodule

// File: tb/sector_prog_ctrl_tb.sv
`timescale 1ns/1ps
module sector_prog_ctrl_tb;
   localparam int unsigned AW = 11;
   localparam int unsigned LW = 8;
   localparam int unsigned PC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic          busy;
   logic          sector_err;

   always #2.5 clk = ~clk;

   sector_prog_ctrl #(.ADDR_W(AW), .IDX_W(8), .LOAD_WINDOW(LW), .PROG_CYCLES(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .busy(busy), .sector_err(sector_err));

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t   sbq[$];
   int         n_checks = 0;
   int         n_fail = 0;
   int         cyc = 0;
   int         tl = 0;
   logic       last_b7 = 1'b0;
   logic       exp_tog = 1'b0;
   bit         done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [AW-1:0] mk(input int sect, input int idx);
      return AW'((sect << 8) | idx);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // each task is entered at a negedge and consumes exactly one clock edge
   task automatic load(input int sect, input int idx, input logic [7:0] d, input bit first);
      wr_en = 1'b1; wr_addr = mk(sect, idx); wr_data = d;
      if (first) exp_tog = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      tl = cyc;
   endtask

   task automatic stray(input int sect, input int idx, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = mk(sect, idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int sect, input int idx, input logic [7:0] exp, input string tag);
      sb_item_t it;
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      rd_en = 1'b1; rd_addr = mk(sect, idx);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic stat_rd(input string tag);
      rd(0, 0, {~last_b7, exp_tog, 6'b000000}, tag);
      exp_tog = ~exp_tog;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_done(input string tag);
      int guard = 0;
      while (busy && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      check(tag, cyc - tl, LW + PC);
   endtask

   // monitor: pops the oldest expected read result on each valid output
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sbq.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R11 unexpected rd_valid: actual %0h expected none", rd_data);
         end else begin
            sb_item_t it;
            it = sbq.pop_front();
            check(it.tag, rd_data, it.exp);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10 reset busy", busy, 0);
      check("R10 reset sector_err", sector_err, 0);
      check("R10 reset rd_valid", rd_valid, 0);
      rd(4, 35, 8'hFF, "R11 erased read");
      idle(1);

      // Phase A: sector 2, loads out of order with an overwrite
      load(2, 5, 8'h3C, 1);
      check("R10 busy after first load", busy, 1);
      idle(2);
      load(2, 200, 8'hA7, 0);
      idle(2);
      load(2, 5, 8'h81, 0);
      last_b7 = 1'b1;
      idle(1);
      check("R8 err clear before stray", sector_err, 0);
      stray(3, 0, 8'h12);
      check("R8 err set by stray", sector_err, 1);
      stat_rd("R6 R7 busy read 0");
      stat_rd("R6 R7 busy read 1");
      stat_rd("R6 R7 busy read 2");
      stat_rd("R6 R7 busy read 3");
      idle(5);
      check("R10 busy in program", busy, 1);
      stray(2, 7, 8'h00);
      wait_done("R3 R5 R8 timing phase A");
      check("R8 err sticky", sector_err, 1);
      rd(2, 5, 8'h81, "R2 overwrite wins");
      rd(2, 200, 8'hA7, "R2 out of order byte");
      rd(2, 7, 8'hFF, "R9 write in program ignored");
      rd(2, 0, 8'hFF, "R4 unloaded byte");
      rd(3, 0, 8'hFF, "R8 R1 stray sector untouched");
      idle(1);

      // Phase B: load on the final window cycle, read on the commit edge
      load(5, 255, 8'h5A, 1);
      idle(LW - 1);
      load(5, 0, 8'h11, 0);
      last_b7 = 1'b0;
      stat_rd("R6 R7 status inverted bit7");
      idle(LW + PC - 2);
      stat_rd("R7 status on commit edge");
      check("R5 busy low after commit edge", busy, 0);
      check("R5 commit edge count", cyc - tl, LW + PC);
      rd(5, 255, 8'h5A, "R3 early byte kept");
      rd(5, 0, 8'h11, "R3 late byte accepted");
      rd(5, 1, 8'hFF, "R4 unloaded byte B");
      idle(1);

      // Phase C: reprogram sector 2 with one byte
      load(2, 200, 8'h01, 1);
      last_b7 = 1'b0;
      wait_done("R5 timing phase C");
      rd(2, 5, 8'hFF, "R4 old byte erased");
      rd(2, 200, 8'h01, "R7 true data after busy");
      rd(5, 255, 8'h5A, "R1 other sector kept");
      idle(3);
      check("R11 scoreboard drained", sbq.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule